// File: doc/BRIEF.md
# Long Integer Multiply-Accumulate Unit

This block multiplies two 32-bit operands over many cycles, one multiplier bit per cycle. It has four operating modes: a 32-bit multiply that keeps only the low word, an unsigned 64-bit product, a signed 64-bit product, and an unsigned 64-bit product plus a 64-bit accumulator. The accumulator is supplied as a high word and a low word. The result comes out as two 32-bit words, together with a negative flag and a zero flag. The carry and overflow flags pass through the block unchanged. Any mode code that is not defined produces a zero result and raises an illegal-mode output.

The controller is a three-state machine. In `IDLE` the unit waits, and a `start` pulse captures the operands, the mode and the incoming flags (transition IDLE->RUN). In `RUN` the shift-add datapath retires one multiplier bit per cycle and stays in RUN for 32 cycles. After the last bit it moves to `FIN` (transition RUN->FIN), where `done` is high for exactly one cycle. FIN always returns to IDLE (transition FIN->IDLE). The result outputs keep their value until the next accepted start.

Top module: `lmac_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `flag_n`, `c_out` and `v_out` are 0, both result words are 0, and `flag_z` is 1.
- R2: Mode code 0 puts the low 32 bits of `op_a*op_b` on `res_lo` and drives `res_hi` to 0.
- R3: Mode code 4 zero-extends both operands and returns the full 64-bit product, with the high word on `res_hi` and the low word on `res_lo`.
- R4: Mode code 6 sign-extends both operands to 64 bits before the multiply and returns the 64-bit product.
- R5: Mode code 7 adds `{acc_hi, acc_lo}` to the unsigned 64-bit product, and the sum wraps modulo 2^64.
- R6: `flag_n` equals bit 63 of `{res_hi,res_lo}` in modes 4, 6 and 7, and bit 31 of `res_lo` in mode 0. `flag_z` is 1 exactly when both result words are zero.
- R7: `c_out` and `v_out` equal the values of `c_in` and `v_in` captured at the accepted start, and they hold them until the next accepted start.
- R8: `done` is a one-cycle pulse, 32 clock cycles after the edge that accepts `start`. The result outputs then stay unchanged until the next accepted start.
- R9: Mode codes 1, 2, 3 and 5 complete with the same latency, a zero result, `flag_n`=0, `flag_z`=1 and `illegal`=1. In modes 0, 4, 6 and 7, `illegal` is 0.
- R10: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither that operation's result nor its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| mode | input | 3 | Operation select (0, 4, 6, 7 defined) |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| acc_hi | input | 32 | Accumulator high word (mode 7) |
| acc_lo | input | 32 | Accumulator low word (mode 7) |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag passed through |
| v_out | output | 1 | Overflow flag passed through |
| illegal | output | 1 | Mode code was undefined |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that operands, accumulator and mode only need to be valid in the cycle where `start` is accepted, and that `start` may otherwise toggle freely, including during RUN. The stimulus meets these assumptions: it drives every input away from the clock edge, clears `start` after a single cycle, and injects extra start pulses with different data in the middle of a run, so that the ignore behaviour is exercised. Operand values are chosen at the sign and width corners: all ones, the most negative value, zero, and accumulator values that wrap.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
    localparam logic [2:0] MODE_LO32 = 3'd0;
    localparam logic [2:0] MODE_U64  = 3'd4;
    localparam logic [2:0] MODE_S64  = 3'd6;
    localparam logic [2:0] MODE_UACC = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } lmac_state_e;
endpackage

// File: rtl/lmac_mode_dec.sv
module lmac_mode_dec
    import lmac_pkg::*;
(
    input  logic [2:0] mode,
    output logic       is_lo,
    output logic       is_sgn,
    output logic       is_acc,
    output logic       is_ill
);
    always_comb begin
        is_lo  = 1'b0;
        is_sgn = 1'b0;
        is_acc = 1'b0;
        is_ill = 1'b0;
        case (mode)
            MODE_LO32: is_lo  = 1'b1;
            MODE_U64:  ;
            MODE_S64:  is_sgn = 1'b1;
            MODE_UACC: is_acc = 1'b1;
            default:   is_ill = 1'b1;
        endcase
    end
endmodule

// File: rtl/lmac_shift_add.sv
module lmac_shift_add #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           neg_step,
    input  logic [2*W-1:0] mcand_i,
    input  logic [2*W-1:0] init_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] acc_o
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] mcand_q;
    logic [W2-1:0] acc_q;
    logic [W-1:0]  mplier_q;
    logic [W2-1:0] addend;

    // The last step of a signed multiply carries negative weight.
    always_comb begin
        if (!mplier_q[0])
            addend = '0;
        else if (neg_step)
            addend = ~mcand_q + W2'(1);
        else
            addend = mcand_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            acc_q    <= '0;
            mplier_q <= '0;
        end else if (load) begin
            mcand_q  <= mcand_i;
            acc_q    <= init_i;
            mplier_q <= mplier_i;
        end else if (step) begin
            acc_q    <= acc_q + addend;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign acc_o = acc_q;

    assert_load_step_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));
endmodule

// File: rtl/lmac_result_fmt.sv
module lmac_result_fmt #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic           lo_mode,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo,
    output logic           flag_n,
    output logic           flag_z
);
    always_comb begin
        res_hi = lo_mode ? '0 : acc_i[2*W-1:W];
        res_lo = acc_i[W-1:0];
        flag_n = lo_mode ? acc_i[W-1] : acc_i[2*W-1];
        flag_z = (res_hi == '0) && (res_lo == '0);
    end
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic         c_in,
    input  logic         v_in,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         flag_n,
    output logic         flag_z,
    output logic         c_out,
    output logic         v_out,
    output logic         illegal
);
    localparam int W2 = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    lmac_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic lo_q, sgn_q, ill_q, c_q, v_q;
    logic dec_lo, dec_sgn, dec_acc, dec_ill;
    logic load, step, neg_step;
    logic [W2-1:0] mcand_init, acc_init, acc_w;

    lmac_mode_dec u_dec (
        .mode   (mode),
        .is_lo  (dec_lo),
        .is_sgn (dec_sgn),
        .is_acc (dec_acc),
        .is_ill (dec_ill)
    );

    assign load     = (state_q == ST_IDLE) && start;
    assign step     = (state_q == ST_RUN);
    assign neg_step = sgn_q && (cnt_q == LAST);

    always_comb begin
        if (dec_ill)
            mcand_init = '0;
        else if (dec_sgn)
            mcand_init = {{W{op_a[W-1]}}, op_a};
        else
            mcand_init = {{W{1'b0}}, op_a};
        acc_init = dec_acc ? {acc_hi, acc_lo} : '0;
    end

    lmac_shift_add #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .neg_step (neg_step),
        .mcand_i  (mcand_init),
        .init_i   (acc_init),
        .mplier_i (op_b),
        .acc_o    (acc_w)
    );

    lmac_result_fmt #(.W(W)) u_fmt (
        .acc_i   (acc_w),
        .lo_mode (lo_q),
        .res_hi  (res_hi),
        .res_lo  (res_lo),
        .flag_n  (flag_n),
        .flag_z  (flag_z)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Captured mode, flags and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lo_q  <= 1'b0;
            sgn_q <= 1'b0;
            ill_q <= 1'b0;
            c_q   <= 1'b0;
            v_q   <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            lo_q  <= dec_lo;
            sgn_q <= dec_sgn;
            ill_q <= dec_ill;
            c_q   <= c_in;
            v_q   <= v_in;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        done    = (state_q == ST_FIN);
        illegal = ill_q;
        c_out   = c_q;
        v_out   = v_q;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q) == ST_RUN);
    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (res_hi == '0 && res_lo == '0 && flag_z));
    assert_lo_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lo_q) |-> (res_hi == '0));
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(c_out) && $stable(v_out)));
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start) |=> ($stable(lo_q) && $stable(sgn_q) && $stable(ill_q)));
endmodule

// File: tb/lmac_unit_bench.sv
`timescale 1ns/1ps
module lmac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] op_a = '0, op_b = '0, acc_hi = '0, acc_lo = '0;
    logic        c_in = 1'b0, v_in = 1'b0;
    logic        done, flag_n, flag_z, c_out, v_out, illegal;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [63:0] res;
        logic        n;
        logic        z;
        logic        ill;
        logic        c;
        logic        v;
        logic [31:0] due;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lmac_unit u_lmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .c_in(c_in), .v_in(v_in), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .flag_n(flag_n), .flag_z(flag_z), .c_out(c_out), .v_out(v_out), .illegal(illegal)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design reports completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_exp.size() == 0) begin
                check("R8", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, "result", {res_hi, res_lo}, e.res);
                check("R6", "flag_n", {63'd0, flag_n}, {63'd0, e.n});
                check("R6", "flag_z", {63'd0, flag_z}, {63'd0, e.z});
                check("R9", "illegal", {63'd0, illegal}, {63'd0, e.ill});
                check("R7", "carry/overflow", {62'd0, c_out, v_out}, {62'd0, e.c, e.v});
                check("R8", "done cycle", 64'(cyc), 64'(e.due));
            end
        end
    end

    task automatic run_op(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] acc, input logic c, input logic v,
                          input string tag, input bit poke);
        exp_t e;
        logic [63:0] p;
        logic [31:0] lo32;
        lo32 = a * b;
        case (m)
            3'd0: p = {32'd0, lo32};
            3'd4: p = {32'd0, a} * {32'd0, b};
            3'd6: p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
            3'd7: p = {32'd0, a} * {32'd0, b} + acc;
            default: p = 64'd0;
        endcase
        e.res = p;
        e.n   = (m == 3'd0) ? p[31] : p[63];
        e.z   = (p == 64'd0);
        e.ill = !(m == 3'd0 || m == 3'd4 || m == 3'd6 || m == 3'd7);
        e.c   = c;
        e.v   = v;
        e.due = 32'(cyc + 33);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        mode = m; op_a = a; op_b = b; acc_hi = acc[63:32]; acc_lo = acc[31:0];
        c_in = c; v_in = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode = 3'd5; op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; c_in = ~c; v_in = ~v;
        for (int i = 0; i < 36; i++) begin
            @(negedge clk);
            if (poke && (i == 4 || i == 20)) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        // R8: result and flags held after completion
        check("R8", "held result", {res_hi, res_lo}, p);
        check("R7", "held carry/overflow", {62'd0, c_out, v_out}, {62'd0, c, v});
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset result", {res_hi, res_lo}, 64'd0);
        check("R1", "reset done/illegal/n/c/v", {59'd0, done, illegal, flag_n, c_out, v_out}, 64'd0);
        check("R1", "reset flag_z", {63'd0, flag_z}, 64'd1);

        run_op(3'd0, 32'd3, 32'd5, 64'd0, 1'b1, 1'b0, "R2", 1'b0);
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b1, "R2", 1'b0);
        run_op(3'd0, 32'h8000_0000, 32'd1, 64'd0, 1'b1, 1'b1, "R6", 1'b0);
        run_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0, "R3", 1'b0);
        run_op(3'd4, 32'd0, 32'h1234_5678, 64'd0, 1'b0, 1'b0, "R3", 1'b0);
        run_op(3'd4, 32'h8000_0001, 32'h0000_0003, 64'd0, 1'b1, 1'b0, "R3", 1'b0);
        run_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0, "R4", 1'b0);
        run_op(3'd6, 32'hFFFF_FFFE, 32'd3, 64'd0, 1'b0, 1'b1, "R4", 1'b0);
        run_op(3'd6, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b0, 1'b0, "R4", 1'b0);
        run_op(3'd6, 32'd7, 32'h8000_0000, 64'd0, 1'b1, 1'b1, "R4", 1'b0);
        run_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R5", 1'b0);
        run_op(3'd7, 32'd10, 32'd20, 64'h0000_0001_0000_0005, 1'b1, 1'b0, "R5", 1'b0);
        run_op(3'd3, 32'd9, 32'd9, 64'd0, 1'b0, 1'b1, "R9", 1'b0);
        run_op(3'd5, 32'hFFFF_FFFF, 32'd2, 64'd5, 1'b1, 1'b0, "R9", 1'b0);
        run_op(3'd4, 32'h0001_0000, 32'h0001_0000, 64'd0, 1'b1, 1'b1, "R10", 1'b1);
        run_op(3'd6, 32'hFFFF_0000, 32'h0000_FFFF, 64'd0, 1'b0, 1'b1, "R10", 1'b1);

        check("R8", "scoreboard drained", 64'(q_exp.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule